// File: doc/BRIEF.md
# Two-Wire Serial Register Slave with Idle Resync and Soft Reset

This block is the slave end of a two-wire serial link: one clock line driven by the host and one shared data line. The host sends one byte of header, a direction bit followed by a 7-bit register address. It then sends one data byte, or receives one data byte from the slave. There is no select line. Frame alignment comes from an inactivity watchdog instead: if the clock line shows no edge for `TIMEOUT` system clocks in the middle of a frame, the port drops what it has collected and treats the next rising edge as a new direction bit.

Both link lines are brought into the system clock domain through flop synchronisers, and their edges are detected there. A read is answered after a turnaround of `TURN_FALLS` falling edges. The slave drives the line through a separate output value and output enable, so the pad can sit outside the block. Register 0 is the configuration register. Setting its top bit starts a soft reset. The soft reset clears every other register, restarts the settle counter and puts the port back into its post-reset hold. Bits 6:0 of the written byte stay in the configuration register, and the top bit clears itself one clock later. A `ready` output rises after `SETTLE_TICKS` frame-tick pulses have been counted following any reset.

The control path is one state machine with six states.
- `ST_HOLD`: the post-reset quiet wait. It moves to `ST_ADDR` once the clock line has been idle for `TIMEOUT` clocks.
- `ST_ADDR`: collects the 8 header bits. It moves to `ST_WDATA` when the direction bit is 1 and to `ST_TURN` when it is 0.
- `ST_WDATA`: collects the 8 write bits. It moves to `ST_SRST` when register 0 is written with the top bit set, and to `ST_ADDR` otherwise.
- `ST_TURN`: counts the turnaround falling edges, then moves to `ST_RDATA`.
- `ST_RDATA`: shifts the byte out. It moves to `ST_ADDR` after the 8th rising edge.
- `ST_SRST`: lasts one clock, then moves to `ST_HOLD`.

An idle timeout in `ST_ADDR`, `ST_WDATA`, `ST_TURN` or `ST_RDATA` forces a return to `ST_ADDR` with the bit count cleared.

Top module: `sio_reg_slave`

## Requirements
- R1: A frame starts with a direction bit (1 = write, 0 = read) and then a 7-bit address, most significant bit first. All bits are sampled on rising edges of `sck_in`.
- R2: In a write, 8 data bits follow, most significant bit first, and are stored in the register at the address. Addresses at or above `NREGS` (default 4) store nothing.
- R3: In a read, the slave drives bit 7 on the `TURN_FALLS`-th falling edge (default 2) after the address. It drives each following bit on the next falling edge, and drops `sdio_oe` after the 8th rising edge. An unmapped address reads 0x00.
- R4: If `sck_in` shows no edge for `TIMEOUT` clocks (default 64) in the middle of a frame, the partial frame is discarded and `sdio_oe` is released. The next rising edge is then taken as a direction bit.
- R5: After `rst_n` or a soft reset, the port ignores all `sck_in` traffic until `sck_in` has been quiet for `TIMEOUT` clocks.
- R6: Writing register 0 with bit 7 set returns registers 1 to `NREGS-1` to 0x00 and puts the port into hold. Writing register 0 with bit 7 clear causes no reset.
- R7: Bits 6:0 written together with the reset bit remain in register 0 after the soft reset.
- R8: Bit 7 of `cfg_q` is high for exactly one clock and then clears without any host write.
- R9: `ready` is low after any reset until `SETTLE_TICKS` (default 3) `frame_tick` pulses have been counted. It then stays high until the next reset.
- R10: While and right after `rst_n` is low, `sdio_oe`, `ready` and `cfg_q` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| sck_in | input | 1 | Serial clock from the host, idles high |
| sdio_in | input | 1 | Data line as seen at the pad |
| sdio_out | output | 1 | Data value driven during a read |
| sdio_oe | output | 1 | Drive enable for the data line |
| frame_tick | input | 1 | One-clock pulse per frame period |
| ready | output | 1 | Settled flag after reset |
| cfg_q | output | 8 | Configuration register contents |

## Verification
A pin edge on `sck_in` reaches the state machine three system clocks later: two synchroniser flops and one state register. Register writes, the drive of each read bit and the release of `sdio_oe` therefore settle 3 clocks after the edge that causes them. The bench holds each serial clock phase for 8 clocks and samples at the end of a phase, so every value is read well after it is due. The soft reset completes 4 clocks after the last write edge, and `ready` rises one clock after the counted `frame_tick`; the bench samples those at least 2 clocks later. Hold and resync windows are exercised by waiting `TIMEOUT` plus 16 clocks of silence.

// File: rtl/sio_pkg.sv
package sio_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 7;

    typedef enum logic [2:0] {
        ST_HOLD,
        ST_ADDR,
        ST_WDATA,
        ST_TURN,
        ST_RDATA,
        ST_SRST
    } sio_state_e;
endpackage

// File: rtl/sio_sync.sv
// Flop synchroniser for the serial lines plus edge detection on the clock line.
module sio_sync #(
    parameter int STAGES = 2  // at least 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_in,
    input  logic sdio_in,
    output logic sck_rise,
    output logic sck_fall,
    output logic sdi
);
    logic [STAGES:0]   sck_pipe;
    logic [STAGES-1:0] dat_pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_pipe <= '1;
            dat_pipe <= '0;
        end else begin
            sck_pipe <= {sck_pipe[STAGES-1:0], sck_in};
            dat_pipe <= {dat_pipe[STAGES-2:0], sdio_in};
        end
    end

    assign sck_rise = sck_pipe[STAGES-1] & ~sck_pipe[STAGES];
    assign sck_fall = ~sck_pipe[STAGES-1] & sck_pipe[STAGES];
    assign sdi      = dat_pipe[STAGES-1];
endmodule

// File: rtl/sio_ready.sv
// Counts frame ticks after a reset and raises ready once the count is reached.
module sio_ready #(
    parameter int SETTLE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic srst,
    input  logic frame_tick,
    output logic ready
);
    localparam int CNT_W = $clog2(SETTLE_TICKS + 1);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (srst)
            cnt_q <= '0;
        else if (frame_tick && cnt_q != CNT_W'(SETTLE_TICKS))
            cnt_q <= cnt_q + CNT_W'(1);
    end

    assign ready = (cnt_q == CNT_W'(SETTLE_TICKS));
endmodule

// File: rtl/sio_regfile.sv
// Register file; entry 0 is the configuration register whose top bit self-clears on soft reset.
module sio_regfile #(
    parameter int NREGS = 4,
    parameter int AW    = 7,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          srst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] cfg_q
);
    logic [DW-1:0] regs [NREGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (srst) begin
            for (int i = 0; i < NREGS; i++)
                regs[i] <= (i == 0) ? {1'b0, regs[0][DW-2:0]} : '0;
        end else if (wr_en) begin
            for (int i = 0; i < NREGS; i++)
                if (wr_addr == AW'(i)) regs[i] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREGS; i++)
            if (rd_addr == AW'(i)) rd_data = regs[i];
    end

    assign cfg_q = regs[0];
endmodule

// File: rtl/sio_reg_slave.sv
module sio_reg_slave
    import sio_pkg::*;
#(
    parameter int NREGS        = 4,
    parameter int TIMEOUT      = 64,
    parameter int TURN_FALLS   = 2,
    parameter int SETTLE_TICKS = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sck_in,
    input  logic        sdio_in,
    output logic        sdio_out,
    output logic        sdio_oe,
    input  logic        frame_tick,
    output logic        ready,
    output logic [7:0]  cfg_q
);
    localparam int IDLE_W = $clog2(TIMEOUT + 1);
    localparam int TURN_W = $clog2(TURN_FALLS + 1);
    localparam int CNT_W  = $clog2(BYTE_W);

    logic sck_rise, sck_fall, sdi;

    sio_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck_in   (sck_in),
        .sdio_in  (sdio_in),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .sdi      (sdi)
    );

    sio_state_e        state_q, state_d, cur;
    logic [CNT_W-1:0]  cnt_q, cnt_d, cnt_c;
    logic [BYTE_W-1:0] sh_q, sh_d, wr_data, rd_data;
    logic [ADDR_W-1:0] addr_q, addr_d;
    logic [TURN_W-1:0] turn_q, turn_d;
    logic [IDLE_W-1:0] idle_q;
    logic              timeout, abort, wr_en, srst;

    assign timeout = (idle_q == IDLE_W'(TIMEOUT));
    assign srst    = (state_q == ST_SRST);
    assign abort   = timeout && (state_q inside {ST_ADDR, ST_WDATA, ST_TURN, ST_RDATA});
    assign wr_data = {sh_q[BYTE_W-2:0], sdi};

    // Idle watchdog on the serial clock line
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idle_q <= '0;
        else if (srst || sck_rise || sck_fall)
            idle_q <= '0;
        else if (!timeout)
            idle_q <= idle_q + IDLE_W'(1);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            addr_q <= '0;
            turn_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            sh_q   <= sh_d;
            addr_q <= addr_d;
            turn_q <= turn_d;
        end
    end

    // Next state and datapath
    always_comb begin
        cur     = abort ? ST_ADDR : state_q;
        cnt_c   = abort ? '0 : cnt_q;
        state_d = cur;
        cnt_d   = cnt_c;
        sh_d    = sh_q;
        addr_d  = addr_q;
        turn_d  = turn_q;
        wr_en   = 1'b0;
        unique case (cur)
            ST_HOLD: begin
                cnt_d = '0;
                if (timeout) state_d = ST_ADDR;
            end
            ST_ADDR: begin
                if (sck_rise) begin
                    sh_d  = wr_data;
                    cnt_d = cnt_c + CNT_W'(1);
                    if (cnt_c == CNT_W'(BYTE_W - 1)) begin
                        addr_d  = wr_data[ADDR_W-1:0];
                        turn_d  = '0;
                        state_d = sh_q[ADDR_W-1] ? ST_WDATA : ST_TURN;
                    end
                end
            end
            ST_WDATA: begin
                if (sck_rise) begin
                    sh_d  = wr_data;
                    cnt_d = cnt_c + CNT_W'(1);
                    if (cnt_c == CNT_W'(BYTE_W - 1)) begin
                        wr_en   = 1'b1;
                        state_d = (addr_q == '0 && wr_data[BYTE_W-1]) ? ST_SRST : ST_ADDR;
                    end
                end
            end
            ST_TURN: begin
                if (sck_fall) begin
                    if (turn_q == TURN_W'(TURN_FALLS - 1)) begin
                        sh_d    = rd_data;
                        cnt_d   = '0;
                        state_d = ST_RDATA;
                    end else begin
                        turn_d = turn_q + TURN_W'(1);
                    end
                end
            end
            ST_RDATA: begin
                if (sck_fall) begin
                    sh_d = {sh_q[BYTE_W-2:0], 1'b0};
                end else if (sck_rise) begin
                    cnt_d = cnt_c + CNT_W'(1);
                    if (cnt_c == CNT_W'(BYTE_W - 1)) state_d = ST_ADDR;
                end
            end
            ST_SRST: begin
                cnt_d   = '0;
                state_d = ST_HOLD;
            end
            default: state_d = ST_HOLD;
        endcase
    end

    // Outputs
    always_comb begin
        sdio_oe  = (state_q == ST_RDATA);
        sdio_out = (state_q == ST_RDATA) ? sh_q[BYTE_W-1] : 1'b0;
    end

    sio_regfile #(.NREGS(NREGS), .AW(ADDR_W), .DW(BYTE_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .srst    (srst),
        .wr_en   (wr_en),
        .wr_addr (addr_q),
        .wr_data (wr_data),
        .rd_addr (addr_q),
        .rd_data (rd_data),
        .cfg_q   (cfg_q)
    );

    sio_ready #(.SETTLE_TICKS(SETTLE_TICKS)) u_ready (
        .clk        (clk),
        .rst_n      (rst_n),
        .srst       (srst),
        .frame_tick (frame_tick),
        .ready      (ready)
    );
endmodule

// File: rtl/sio_checker.sv
module sio_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       sdio_oe,
    input logic       frame_tick,
    input logic       ready,
    input logic [7:0] cfg_q
);
    AST_RESET_BIT_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[7] |=> !cfg_q[7]); // R8

    AST_LOW_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[7] |=> (cfg_q[6:0] == $past(cfg_q[6:0]))); // R7

    AST_READY_DROPS_ON_SRST: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[7] |=> !ready); // R9

    AST_PORT_QUIET_ON_SRST: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[7] |=> !sdio_oe); // R6

    AST_READY_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(frame_tick)); // R9
endmodule

bind sio_reg_slave sio_checker u_chk (.*);

// File: tb/tb_sio_reg_slave.sv
`timescale 1ns/1ps
module tb_sio_reg_slave;
    localparam int HP = 8;
    localparam int TO = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b1;
    logic       sdi = 1'b0;
    logic       sdo, oe, ready;
    logic       ftick = 1'b0;
    logic [7:0] cfg;
    int         n_chk = 0;
    int         n_fail = 0;
    int         b7_cycles = 0;

    always #2 clk = ~clk;

    sio_reg_slave dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck_in     (sck),
        .sdio_in    (sdi),
        .sdio_out   (sdo),
        .sdio_oe    (oe),
        .frame_tick (ftick),
        .ready      (ready),
        .cfg_q      (cfg)
    );

    always @(negedge clk) if (cfg[7]) b7_cycles++;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        sck = 1'b0;
        sdi = b;
        wait_clk(HP);
        sck = 1'b1;
        wait_clk(HP);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
    endtask

    task automatic wr(input logic [6:0] a, input logic [7:0] d);
        send_byte({1'b1, a});
        send_byte(d);
    endtask

    task automatic rd(input logic [6:0] a, output logic [7:0] d, output logic oe_ok);
        oe_ok = 1'b1;
        send_byte({1'b0, a});
        send_bit(1'b0);  // turnaround cycle
        for (int i = 7; i >= 0; i--) begin
            @(negedge clk);
            sck = 1'b0;
            wait_clk(HP);
            d[i] = sdo;
            oe_ok &= oe;
            sck = 1'b1;
            wait_clk(HP);
        end
        wait_clk(HP);
        if (oe) oe_ok = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        ftick = 1'b1;
        @(negedge clk);
        ftick = 1'b0;
        wait_clk(2);
    endtask

    task automatic test_reset();
        check("R10 oe in reset", oe, 0);
        check("R10 ready in reset", ready, 0);
        check("R10 cfg in reset", cfg, 0);
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(2);
        check("R10 oe after reset", oe, 0);
        check("R10 cfg after reset", cfg, 0);
    endtask

    task automatic test_ready();
        tick();
        tick();
        check("R9 ready after 2 ticks", ready, 0);
        tick();
        check("R9 ready after 3 ticks", ready, 1);
        tick();
        check("R9 ready stays high", ready, 1);
    endtask

    task automatic test_hold();
        logic [7:0] d;
        logic ok;
        wr(7'd1, 8'hA5);  // still inside the post-reset quiet window
        wait_clk(TO + 16);
        rd(7'd1, d, ok);
        check("R5 write during hold ignored", d, 8'h00);
    endtask

    task automatic test_write_read();
        logic [7:0] d;
        logic ok;
        wr(7'd1, 8'h5A);
        wr(7'd2, 8'hC3);
        wr(7'd3, 8'h0F);
        rd(7'd1, d, ok);
        check("R1 R2 reg1 readback", d, 8'h5A);
        check("R3 oe during read and release", ok, 1);
        rd(7'd2, d, ok);
        check("R2 R3 reg2 readback", d, 8'hC3);
        rd(7'd3, d, ok);
        check("R2 R3 reg3 readback", d, 8'h0F);
    endtask

    task automatic test_unmapped();
        logic [7:0] d;
        logic ok;
        wr(7'h45, 8'hFF);
        rd(7'h45, d, ok);
        check("R3 unmapped reads zero", d, 8'h00);
        rd(7'd1, d, ok);
        check("R2 unmapped write stores nothing", d, 8'h5A);
        check("R2 cfg untouched", cfg, 8'h00);
    endtask

    task automatic test_resync();
        logic [7:0] d;
        logic ok;
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        wait_clk(TO + 16);
        wr(7'd3, 8'h3C);
        rd(7'd3, d, ok);
        check("R4 recovery after truncated frame", d, 8'h3C);
        send_byte({1'b0, 7'd3});
        send_bit(1'b0);
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        check("R4 oe high mid read", oe, 1);
        wait_clk(TO + 16);
        check("R4 oe released after idle", oe, 0);
        rd(7'd3, d, ok);
        check("R4 read after aborted read", d, 8'h3C);
    endtask

    task automatic test_soft_reset();
        logic [7:0] d;
        logic ok;
        wr(7'd0, 8'h2A);
        rd(7'd1, d, ok);
        check("R6 no reset without bit7", d, 8'h5A);
        check("R6 cfg plain write", cfg, 8'h2A);
        b7_cycles = 0;
        wr(7'd0, 8'h95);
        check("R7 low bits kept", cfg, 8'h15);
        check("R8 bit7 high one cycle", b7_cycles, 1);
        check("R9 ready low after soft reset", ready, 0);
        wr(7'd2, 8'h99);  // inside the new quiet window
        wait_clk(TO + 16);
        rd(7'd1, d, ok);
        check("R6 reg1 cleared", d, 8'h00);
        rd(7'd2, d, ok);
        check("R5 R6 write during hold ignored", d, 8'h00);
        rd(7'd0, d, ok);
        check("R7 cfg readback", d, 8'h15);
        tick();
        tick();
        check("R9 not ready after 2 ticks", ready, 0);
        tick();
        check("R9 ready after 3 ticks", ready, 1);
        b7_cycles = 0;
        wr(7'd0, 8'h80);
        check("R7 bare reset command", cfg, 8'h00);
        check("R8 bit7 single cycle", b7_cycles, 1);
    endtask

    initial begin
        test_reset();
        test_ready();
        test_hold();
        test_write_read();
        test_unmapped();
        test_resync();
        test_soft_reset();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule